// File: doc/BRIEF.md
# Microcoded Sequencer with Opcode Dispatch

This block steps a multicycle processor through its instructions from a control store. A 4-bit microaddress register picks one word from a built-in control memory. Each word has two parts: a group of datapath control fields, which drive the rest of the processor for that cycle, and a 2-bit next-address code. The next-address code tells a small selector where the sequencer goes after the current cycle. It can go back to microaddress zero, which fetches the next instruction. It can jump through one of two opcode-indexed dispatch tables. It can also step to the current microaddress plus one.

The first dispatch table splits decode by instruction class: register-register, load/store address calculation, branch, jump and OR-immediate. The second table separates load from store once the address has been computed. If an opcode is not in the table in use, the sequencer returns to microaddress zero. The block is fed by the clock, an active-low reset and the opcode held in the instruction register. It puts out the current control word and the current microaddress. Its control fields match the per-state outputs of a hardwired controller for the same datapath, so the two controllers can be compared cycle by cycle.

Top module: `useq_ctrl`

## Requirements
- R1: Driving rst_n low forces the microaddress to 0 at once, without waiting for a clock edge, and the control word becomes 0x50003. After rst_n rises, the sequencer advances normally from 0 on the next rising edge.
- R2: A word whose next-address code (bits 1:0) is 3 moves the microaddress to the current value plus one on the next rising edge. Microaddresses 0, 3, 6 and 10 carry this code.
- R3: A word whose code is 1 (microaddress 1) moves the sequencer through the first table. The opcode mapping is 000000→6, 000010→9, 000100→8, 001011→10, 100011→2 and 101011→2.
- R4: A word whose code is 2 (microaddress 2) moves the sequencer through the second table. The opcode mapping is 100011→3 and 101011→5.
- R5: A word whose code is 0 returns the microaddress to 0 on the next rising edge. Microaddresses 4, 5, 7, 8, 9 and 11 carry this code.
- R6: An opcode that is missing from the table in use sends the sequencer to microaddress 0.
- R7: The opcode has no effect on the next microaddress when the current code is 0 or 3.
- R8: The control word is laid out as follows: bit 18 pc write, bit 17 conditional pc write, bit 16 instruction register write, bit 15 memory write, bit 14 memory address from data, bit 13 register write, bit 12 destination is rd, bit 11 write-back from memory, bit 10 branch target write, bit 9 sign extend, bit 8 ALU A from register, bits 7:6 ALU B source (0 constant 4, 1 register, 2 shifted offset, 3 immediate), bits 5:4 ALU operation (0 add, 1 sub, 2 or, 3 function field), bits 3:2 pc source (0 ALU, 1 target, 2 jump), bits 1:0 next-address code. The words for microaddresses 0 to 11 are 0x50003, 0x00681, 0x003C2, 0x043C3, 0x02BC0, 0x0C3C0, 0x01173, 0x03170, 0x20154, 0x40008, 0x001E3 and 0x021E0.
- R9: When reset is held low across a rising edge, it takes priority over a dispatch that would otherwise happen in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the microaddress updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| opcode | input | OP_W (6) | Opcode of the instruction being executed |
| ctrl_word | output | CW_W (19) | Control word of the current microaddress |
| state | output | ST_W (4) | Current microaddress |

## Verification
Reset and table dispatch can both claim the next microaddress in the same cycle. The bench provokes this by bringing the sequencer to microaddress 2 with a load opcode present, then pulling rst_n low before the edge that would dispatch to 3. It judges the outcome twice. Immediately after rst_n falls, the microaddress must already read 0. After the edge it must still be 0 rather than 3. The opcode is also changed in increment and return-to-zero states, and the bench checks that the next microaddress does not follow it.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_ZERO  = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_INC   = 2'd3
  } seq_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_OR   = 2'd2,
    ALU_FUNC = 2'd3
  } alu_op_e;

  localparam logic [1:0] BSRC_FOUR = 2'd0;
  localparam logic [1:0] BSRC_REG  = 2'd1;
  localparam logic [1:0] BSRC_OFS  = 2'd2;
  localparam logic [1:0] BSRC_IMM  = 2'd3;

  localparam logic [1:0] PSRC_ALU  = 2'd0;
  localparam logic [1:0] PSRC_TGT  = 2'd1;
  localparam logic [1:0] PSRC_JMP  = 2'd2;

  localparam logic [5:0] OPC_RRR   = 6'b000000;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_ORI   = 6'b001011;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  typedef struct packed {
    logic     pc_wr;
    logic     pc_wr_cond;
    logic     ir_wr;
    logic     mem_wr;
    logic     mem_adr_data;
    logic     reg_wr;
    logic     reg_dst_rd;
    logic     reg_from_mem;
    logic     tgt_wr;
    logic     ext_sign;
    logic     alu_a_reg;
    logic [1:0] alu_b_sel;
    alu_op_e  alu_op;
    logic [1:0] pc_src;
    seq_sel_e seq;
  } uword_t;

  function automatic uword_t uword_for(int unsigned idx);
    uword_t w;
    w = '0;
    case (idx)
      0: begin
        w.pc_wr = 1'b1; w.ir_wr = 1'b1;
        w.alu_b_sel = BSRC_FOUR; w.alu_op = ALU_ADD; w.seq = SEQ_INC;
      end
      1: begin
        w.tgt_wr = 1'b1; w.ext_sign = 1'b1;
        w.alu_b_sel = BSRC_OFS; w.alu_op = ALU_ADD; w.seq = SEQ_DISP1;
      end
      2: begin
        w.ext_sign = 1'b1; w.alu_a_reg = 1'b1;
        w.alu_b_sel = BSRC_IMM; w.alu_op = ALU_ADD; w.seq = SEQ_DISP2;
      end
      3: begin
        w.mem_adr_data = 1'b1; w.ext_sign = 1'b1; w.alu_a_reg = 1'b1;
        w.alu_b_sel = BSRC_IMM; w.alu_op = ALU_ADD; w.seq = SEQ_INC;
      end
      4: begin
        w.reg_wr = 1'b1; w.reg_from_mem = 1'b1; w.ext_sign = 1'b1;
        w.alu_a_reg = 1'b1; w.alu_b_sel = BSRC_IMM; w.alu_op = ALU_ADD;
        w.seq = SEQ_ZERO;
      end
      5: begin
        w.mem_wr = 1'b1; w.mem_adr_data = 1'b1; w.ext_sign = 1'b1;
        w.alu_a_reg = 1'b1; w.alu_b_sel = BSRC_IMM; w.alu_op = ALU_ADD;
        w.seq = SEQ_ZERO;
      end
      6: begin
        w.reg_dst_rd = 1'b1; w.alu_a_reg = 1'b1;
        w.alu_b_sel = BSRC_REG; w.alu_op = ALU_FUNC; w.seq = SEQ_INC;
      end
      7: begin
        w.reg_wr = 1'b1; w.reg_dst_rd = 1'b1; w.alu_a_reg = 1'b1;
        w.alu_b_sel = BSRC_REG; w.alu_op = ALU_FUNC; w.seq = SEQ_ZERO;
      end
      8: begin
        w.pc_wr_cond = 1'b1; w.alu_a_reg = 1'b1; w.alu_b_sel = BSRC_REG;
        w.alu_op = ALU_SUB; w.pc_src = PSRC_TGT; w.seq = SEQ_ZERO;
      end
      9: begin
        w.pc_wr = 1'b1; w.pc_src = PSRC_JMP; w.seq = SEQ_ZERO;
      end
      10: begin
        w.alu_a_reg = 1'b1; w.alu_b_sel = BSRC_IMM;
        w.alu_op = ALU_OR; w.seq = SEQ_INC;
      end
      11: begin
        w.reg_wr = 1'b1; w.alu_a_reg = 1'b1; w.alu_b_sel = BSRC_IMM;
        w.alu_op = ALU_OR; w.seq = SEQ_ZERO;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W      = 6,
  parameter int ST_W      = 4,
  parameter int TABLE_SEL = 1
) (
  input  logic [OP_W-1:0] opcode,
  output logic            hit,
  output logic [ST_W-1:0] target
);

  generate
    if (TABLE_SEL == 1) begin : g_decode_tbl
      // R3: class split after decode
      always_comb begin
        hit    = 1'b1;
        target = '0;
        if (opcode == OP_W'(OPC_RRR))        target = ST_W'(6);
        else if (opcode == OP_W'(OPC_JUMP))  target = ST_W'(9);
        else if (opcode == OP_W'(OPC_BEQ))   target = ST_W'(8);
        else if (opcode == OP_W'(OPC_ORI))   target = ST_W'(10);
        else if (opcode == OP_W'(OPC_LOAD))  target = ST_W'(2);
        else if (opcode == OP_W'(OPC_STORE)) target = ST_W'(2);
        else                                 hit    = 1'b0;
      end
    end else begin : g_memop_tbl
      // R4: load/store split after address calculation
      always_comb begin
        hit    = 1'b1;
        target = '0;
        if (opcode == OP_W'(OPC_LOAD))       target = ST_W'(3);
        else if (opcode == OP_W'(OPC_STORE)) target = ST_W'(5);
        else                                 hit    = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/useq_next_addr.sv
`timescale 1ns/1ps
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ST_W = 4
) (
  input  seq_sel_e        sel,
  input  logic [ST_W-1:0] cur_addr,
  input  logic            d1_hit,
  input  logic [ST_W-1:0] d1_addr,
  input  logic            d2_hit,
  input  logic [ST_W-1:0] d2_addr,
  output logic [ST_W-1:0] nxt_addr
);

  always_comb begin
    nxt_addr = '0;
    unique case (sel)
      SEQ_ZERO:  nxt_addr = '0;                              // R5
      SEQ_DISP1: nxt_addr = d1_hit ? d1_addr : '0;           // R3, R6
      SEQ_DISP2: nxt_addr = d2_hit ? d2_addr : '0;           // R4, R6
      SEQ_INC:   nxt_addr = cur_addr + ST_W'(1);             // R2
      default:   nxt_addr = '0;
    endcase
  end

endmodule

// File: rtl/useq_ctrl_store.sv
`timescale 1ns/1ps
module useq_ctrl_store
  import useq_pkg::*;
#(
  parameter int ST_W     = 4,
  parameter int N_STATES = 12
) (
  input  logic [ST_W-1:0] addr,
  output uword_t          word
);

  uword_t rom [N_STATES];

  generate
    for (genvar i = 0; i < N_STATES; i++) begin : g_word
      assign rom[i] = uword_for(i);
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < N_STATES; i++) begin
      if (addr == ST_W'(i)) word = rom[i];
    end
  end

endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W     = 6,
  parameter int ST_W     = 4,
  parameter int N_STATES = 12,
  localparam int CW_W    = $bits(uword_t)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic [CW_W-1:0] ctrl_word,
  output logic [ST_W-1:0] state
);

  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  uword_t          uw;
  logic            d1_hit;
  logic            d2_hit;
  logic [ST_W-1:0] d1_addr;
  logic [ST_W-1:0] d2_addr;

  useq_ctrl_store #(.ST_W(ST_W), .N_STATES(N_STATES)) store_i (
    .addr (state_q),
    .word (uw)
  );

  useq_dispatch #(.OP_W(OP_W), .ST_W(ST_W), .TABLE_SEL(1)) disp1_i (
    .opcode (opcode),
    .hit    (d1_hit),
    .target (d1_addr)
  );

  useq_dispatch #(.OP_W(OP_W), .ST_W(ST_W), .TABLE_SEL(2)) disp2_i (
    .opcode (opcode),
    .hit    (d2_hit),
    .target (d2_addr)
  );

  useq_next_addr #(.ST_W(ST_W)) nxt_i (
    .sel      (uw.seq),
    .cur_addr (state_q),
    .d1_hit   (d1_hit),
    .d1_addr  (d1_addr),
    .d2_hit   (d2_hit),
    .d2_addr  (d2_addr),
    .nxt_addr (state_d)
  );

  // R1, R9: asynchronous reset takes priority over any next address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign ctrl_word = uw;
  assign state     = state_q;

  AST_INC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.seq == SEQ_INC) |=> (state_q == $past(state_q) + ST_W'(1))); // R2

  AST_ZERO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.seq == SEQ_ZERO) |=> (state_q == '0)); // R5

  AST_DECODE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_W'(1)) |=> (state_q inside {ST_W'(0), ST_W'(2), ST_W'(6),
                                               ST_W'(8), ST_W'(9), ST_W'(10)})); // R3

  AST_MEMOP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_W'(2)) |=> (state_q inside {ST_W'(0), ST_W'(3), ST_W'(5)})); // R4

  AST_STATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(state_q) < N_STATES)); // R8

endmodule

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb_top;

  localparam logic [5:0] OP_L = 6'b100011;
  localparam logic [5:0] OP_S = 6'b101011;
  localparam logic [5:0] OP_R = 6'b000000;
  localparam logic [5:0] OP_B = 6'b000100;
  localparam logic [5:0] OP_J = 6'b000010;
  localparam logic [5:0] OP_O = 6'b001011;
  localparam logic [5:0] OP_X = 6'b111111;

  // {opcode driven this cycle, expected microaddress this cycle, requirement}
  localparam int N_VEC = 33;
  localparam logic [13:0] VECS [N_VEC] = '{
    {OP_L, 4'd0, 4'd2}, {OP_L, 4'd1, 4'd2}, {OP_L, 4'd2, 4'd3}, {OP_L, 4'd3, 4'd4},
    {OP_L, 4'd4, 4'd2},
    {OP_S, 4'd0, 4'd5}, {OP_S, 4'd1, 4'd2}, {OP_S, 4'd2, 4'd3}, {OP_S, 4'd5, 4'd4},
    {OP_R, 4'd0, 4'd5}, {OP_R, 4'd1, 4'd2}, {OP_R, 4'd6, 4'd3}, {OP_R, 4'd7, 4'd2},
    {OP_B, 4'd0, 4'd5}, {OP_B, 4'd1, 4'd2}, {OP_B, 4'd8, 4'd3},
    {OP_J, 4'd0, 4'd5}, {OP_J, 4'd1, 4'd2}, {OP_J, 4'd9, 4'd3},
    {OP_O, 4'd0, 4'd5}, {OP_O, 4'd1, 4'd2}, {OP_O, 4'd10, 4'd3}, {OP_O, 4'd11, 4'd2},
    {OP_X, 4'd0, 4'd5}, {OP_X, 4'd1, 4'd7},
    {OP_L, 4'd0, 4'd6}, {OP_L, 4'd1, 4'd2}, {OP_B, 4'd2, 4'd3},
    {OP_L, 4'd0, 4'd6}, {OP_L, 4'd1, 4'd2}, {OP_L, 4'd2, 4'd3}, {OP_J, 4'd3, 4'd4},
    {OP_O, 4'd4, 4'd7}
  };
  // Group notes: walk per class covers R2 R3 R4 R5; OP_X in state 0 and
  // OP_J in state 3 cover R7; OP_X in state 1 and OP_B in state 2 cover R6.

  logic        clk;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [18:0] ctrl_word;
  logic [3:0]  state;
  int          n_chk;
  int          n_bad;
  bit          done;

  useq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .state     (state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [18:0] exp_word(logic [3:0] s);
    case (s)
      4'd0:  return 19'h50003;
      4'd1:  return 19'h00681;
      4'd2:  return 19'h003C2;
      4'd3:  return 19'h043C3;
      4'd4:  return 19'h02BC0;
      4'd5:  return 19'h0C3C0;
      4'd6:  return 19'h01173;
      4'd7:  return 19'h03170;
      4'd8:  return 19'h20154;
      4'd9:  return 19'h40008;
      4'd10: return 19'h001E3;
      4'd11: return 19'h021E0;
      default: return 19'h00000;
    endcase
  endfunction

  task automatic chk_state(logic [3:0] exp, int req);
    n_chk++;
    if (state !== exp) begin
      n_bad++;
      $display("FAIL R%0d state actual=%0d expected=%0d", req, state, exp);
    end
  endtask

  task automatic chk_word(logic [3:0] s);
    n_chk++;
    if (ctrl_word !== exp_word(s)) begin
      n_bad++;
      $display("FAIL R8 word at %0d actual=%05h expected=%05h", s, ctrl_word, exp_word(s));
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    opcode = OP_L;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_state(4'd0, 1);   // R1 reset state
    chk_word(4'd0);
    rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      if (i != 0) @(negedge clk);
      opcode = VECS[i][13:8];
      #1;
      chk_state(VECS[i][7:4], int'(VECS[i][3:0]));
      chk_word(VECS[i][7:4]);
    end

    // after the last entry (OP_O in state 4) the sequencer is back at 0
    @(negedge clk);
    opcode = OP_L;
    #1;
    chk_state(4'd0, 5);   // R5
    @(negedge clk);
    #1;
    chk_state(4'd1, 2);   // R2
    @(negedge clk);
    #1;
    chk_state(4'd2, 3);   // R3 load goes to address calculation
    // R1: reset acts at once, before any edge
    rst_n = 1'b0;
    #1;
    chk_state(4'd0, 1);   // R1
    chk_word(4'd0);
    // R9: reset held across the edge that would dispatch to 3
    @(negedge clk);
    #1;
    chk_state(4'd0, 9);   // R9
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_state(4'd1, 1);   // R1 advances after release
    chk_word(4'd1);

    done = 1'b1;
    finish_run();
  end

endmodule